// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. An instruction is fetched at the current program counter and decoded. Its operands are read from a register file with two read ports and one write port. The ALU result, the data-memory access and the next program counter are all settled before the next rising edge. At that edge the register file, the data memory and the program counter are all updated together.

The core supports nine instructions: word load, word store, add, subtract, bitwise and, bitwise or, signed set-less-than, branch-if-equal and an unconditional jump. Instructions and data are held in two separate word arrays inside the core. This lets a fetch and a data access happen in the same cycle. A program-load port fills either array while the core is held in reset. The branch decision reuses the main ALU in subtract mode and tests for a zero result. A dedicated adder forms the branch target. The writeback and store activity of the instruction now executing is visible at the outputs.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and clears every register to zero. While reset is high, neither a register write (`wb_en_o`) nor a data store (`dm_we_o`) is reported.
- R2: One instruction executes per clock. The instruction word is the instruction-array entry at index pc[MEM_AW+1:2]. For every instruction except a taken branch or a jump, the next program counter is PC+4.
- R3: Field layout: the opcode is bits 31:26, the first source register is bits 25:21, the second source register is bits 20:16, the R-type destination is bits 15:11, the shift amount is bits 10:6, the function code is bits 5:0 and the immediate is bits 15:0.
- R4: For opcode 0x00 with a shift amount of zero, the function code selects the operation: 0x20 adds, 0x22 subtracts, 0x24 ands and 0x25 ors. The result goes to the register in bits 15:11.
- R5: Function code 0x2A writes 1 when the first source is less than the second as signed two's-complement numbers, and writes 0 otherwise.
- R6: Opcode 0x23 (load) reads the data word at byte address base + sign-extended immediate. The word is written to the register in bits 20:16. The byte address appears on `dm_addr_o`.
- R7: Opcode 0x2B (store) writes the second source register to the data word at base + sign-extended immediate. It raises `dm_we_o` and performs no register write.
- R8: Opcode 0x04 (branch-if-equal) sets the next PC to PC+4 + (sign-extended immediate shifted left by 2) when the two sources are equal, and to PC+4 otherwise. It performs no register write.
- R9: Opcode 0x02 (jump) sets the next PC to {PC+4[31:28], bits 25:0, 2'b00}.
- R10: Register 0 always reads as zero, and a write to it is dropped (`wb_en_o` stays low).
- R11: Registers are written on the clock edge. An instruction that reads and writes the same register uses the old value, and the following instruction sees the new value.
- R12: An unlisted opcode, an unlisted function code, or a nonzero shift amount in an R-type word performs no register or memory write and advances the PC by 4.
- R13: While `ld_en` is high, the word `ld_data` is written on the clock edge into entry `ld_addr` of the instruction array (`ld_sel`=0) or of the data array (`ld_sel`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Program-load write strobe |
| ld_sel | input | 1 | Load target: 0 instruction array, 1 data array |
| ld_addr | input | MEM_AW | Word index for the load write |
| ld_data | input | 32 | Word written by the load port |
| pc_o | output | 32 | Current program counter |
| wb_en_o | output | 1 | Register write happens at the next edge |
| wb_reg_o | output | 5 | Register number being written |
| wb_data_o | output | 32 | Value being written to the register |
| dm_we_o | output | 1 | Data store happens at the next edge |
| dm_addr_o | output | 32 | Byte address of the data access (ALU result) |
| dm_wdata_o | output | 32 | Store data (second source register) |

## Verification
The assertions assume that the instruction array holds a known word at every index the program counter can reach once reset is released. They also assume that the load port never writes while the core is running, so the fetched word changes only when the PC changes. The bench meets both conditions. It writes every entry of both arrays, filling unused entries with zero words, and it does so only while reset is high. It then drops reset and drives nothing more until the next test.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN = 32;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_JUMP  = 6'h02;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_op_e;

    typedef struct packed {
        logic    reg_write;
        logic    dst_rd;
        logic    use_imm;
        logic    wb_from_mem;
        logic    mem_write;
        logic    is_branch;
        logic    is_jump;
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];
endmodule

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [4:0] shamt,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        unique case (opcode)
            OP_RTYPE: begin
                ctrl.dst_rd    = 1'b1;
                ctrl.reg_write = (shamt == 5'd0);
                unique case (funct)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: ctrl.reg_write = 1'b0;
                endcase
            end
            OP_LOAD: begin
                ctrl.use_imm     = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.reg_write   = 1'b1;
            end
            OP_STORE: begin
                ctrl.use_imm   = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            OP_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_op    = ALU_SUB;
            end
            OP_JUMP: begin
                ctrl.is_jump = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic              ld_sel,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [31:0]       ld_data,
    output logic [31:0]       pc_o,
    output logic              wb_en_o,
    output logic [4:0]        wb_reg_o,
    output logic [31:0]       wb_data_o,
    output logic              dm_we_o,
    output logic [31:0]       dm_addr_o,
    output logic [31:0]       dm_wdata_o
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [XLEN-1:0] imem [DEPTH];
    logic [XLEN-1:0] dmem [DEPTH];

    logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_target, jmp_target;
    logic [XLEN-1:0] instr, imm_ext, rs_data, rt_data, alu_b, alu_y, mem_rd;
    logic [4:0]      dest;
    logic            alu_zero;
    logic            wb_en;
    ctrl_t           ctrl;

    // Instruction fetch and field extraction
    assign instr    = imem[pc_q[MEM_AW+1:2]];
    assign imm_ext  = {{16{instr[15]}}, instr[15:0]};
    assign pc_plus4 = pc_q + 32'd4;

    sc_decode i_decode (
        .opcode (instr[31:26]),
        .shamt  (instr[10:6]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl)
    );

    sc_regfile #(.NREG(32), .W(XLEN)) i_regfile (
        .clk  (clk),
        .rst  (rst),
        .ra_a (instr[25:21]),
        .ra_b (instr[20:16]),
        .rd_a (rs_data),
        .rd_b (rt_data),
        .we   (wb_en),
        .wa   (dest),
        .wd   (wb_data_o)
    );

    // Operand select and execute
    assign alu_b = ctrl.use_imm ? imm_ext : rt_data;

    sc_alu #(.W(XLEN)) i_alu (
        .a    (rs_data),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Data memory and load port
    assign mem_rd = dmem[alu_y[MEM_AW+1:2]];

    always_ff @(posedge clk) begin
        if (ld_en && ld_sel) begin
            dmem[ld_addr] <= ld_data;
        end else if (dm_we_o) begin
            dmem[alu_y[MEM_AW+1:2]] <= rt_data;
        end
    end

    always_ff @(posedge clk) begin
        if (ld_en && !ld_sel) imem[ld_addr] <= ld_data;
    end

    // Writeback select
    assign dest      = ctrl.dst_rd ? instr[15:11] : instr[20:16];
    assign wb_data_o = ctrl.wb_from_mem ? mem_rd : alu_y;
    assign wb_en     = ctrl.reg_write && !rst && (dest != 5'd0);

    // Next-PC selection
    assign br_target  = pc_plus4 + {imm_ext[29:0], 2'b00};
    assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};

    always_comb begin
        if (ctrl.is_jump)                    pc_next = jmp_target;
        else if (ctrl.is_branch && alu_zero) pc_next = br_target;
        else                                 pc_next = pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign pc_o       = pc_q;
    assign wb_en_o    = wb_en;
    assign wb_reg_o   = dest;
    assign dm_we_o    = ctrl.mem_write && !rst;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rt_data;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc,
    input logic [5:0]  opcode,
    input logic [4:0]  rs_field,
    input logic [25:0] jidx,
    input logic [3:0]  pc4_hi,
    input logic [31:0] rs_data,
    input logic [31:0] rt_data,
    input logic        dm_we,
    input logic        wb_en
);
    // R2: sequential flow for all non-control instructions
    p_seq_pc_r2: assert property (@(posedge clk) disable iff (rst)
        (opcode != OP_BEQ && opcode != OP_JUMP) |=> pc == $past(pc) + 32'd4);

    // R8: unequal operands leave the branch untaken
    p_beq_fall_r8: assert property (@(posedge clk) disable iff (rst)
        (opcode == OP_BEQ && rs_data != rt_data) |=> pc == $past(pc) + 32'd4);

    // R9: jump target formed from PC+4 high bits and the index field
    p_jump_tgt_r9: assert property (@(posedge clk) disable iff (rst)
        (opcode == OP_JUMP) |=> pc == {$past(pc4_hi), $past(jidx), 2'b00});

    // R7: a store writes memory and never a register
    p_store_r7: assert property (@(posedge clk) disable iff (rst)
        (opcode == OP_STORE) |-> (dm_we && !wb_en));

    // R10: register 0 reads as zero
    p_zero_reg_r10: assert property (@(posedge clk) disable iff (rst)
        (rs_field == 5'd0) |-> (rs_data == 32'd0));
endmodule

bind sc_core sc_core_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .pc       (pc_q),
    .opcode   (instr[31:26]),
    .rs_field (instr[25:21]),
    .jidx     (instr[25:0]),
    .pc4_hi   (pc_plus4[31:28]),
    .rs_data  (rs_data),
    .rt_data  (rt_data),
    .dm_we    (dm_we_o),
    .wb_en    (wb_en_o)
);

// File: tb/test_sc_core.sv
`timescale 1ns/1ps
module test_sc_core;
    localparam int MEM_AW = 6;
    localparam int DEPTH  = 1 << MEM_AW;
    localparam real HALF  = 4.0;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ld_en = 1'b0;
    logic              ld_sel = 1'b0;
    logic [MEM_AW-1:0] ld_addr = '0;
    logic [31:0]       ld_data = '0;
    logic [31:0]       pc_o, wb_data_o, dm_addr_o, dm_wdata_o;
    logic              wb_en_o, dm_we_o;
    logic [4:0]        wb_reg_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(HALF) clk = ~clk;

    sc_core #(.MEM_AW(MEM_AW)) i_sc_core (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o),
        .wb_en_o(wb_en_o), .wb_reg_o(wb_reg_o), .wb_data_o(wb_data_o),
        .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
    );

    // Encoders built from the field layout of R3
    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(input int idx);
        return {6'h02, 26'(idx)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put(input logic sel, input int idx, input logic [31:0] w);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = sel; ld_addr = MEM_AW'(idx); ld_data = w;
    endtask

    // Hold reset and zero both arrays (R13 load path)
    task automatic boot();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            put(1'b0, i, 32'd0);
            put(1'b1, i, 32'd0);
        end
    endtask

    task automatic go();
        @(negedge clk);
        ld_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic nxt();
        @(negedge clk);
        #1;
    endtask

    task automatic exp_wb(input string tag, input int rd, input logic [31:0] val);
        chk({tag, " wb_en"}, 32'(wb_en_o), 32'd1);
        chk({tag, " wb_reg"}, 32'(wb_reg_o), 32'(rd));
        chk({tag, " wb_data"}, wb_data_o, val);
    endtask

    task automatic exp_quiet(input string tag);
        chk({tag, " wb_en"}, 32'(wb_en_o), 32'd0);
        chk({tag, " dm_we"}, 32'(dm_we_o), 32'd0);
    endtask

    task automatic t_alu();
        logic [31:0] a = 32'hFFFF_FFFD;
        logic [31:0] b = 32'd7;
        boot();
        put(1'b1, 0, a);
        put(1'b1, 1, b);
        put(1'b0, 0, enc_i(6'h23, 0, 1, 0));
        put(1'b0, 1, enc_i(6'h23, 0, 2, 4));
        put(1'b0, 2, enc_r(1, 2, 3, 6'h20));
        put(1'b0, 3, enc_r(1, 2, 4, 6'h22));
        put(1'b0, 4, enc_r(1, 2, 5, 6'h24));
        put(1'b0, 5, enc_r(1, 2, 6, 6'h25));
        put(1'b0, 6, enc_r(1, 2, 7, 6'h2A));
        put(1'b0, 7, enc_r(2, 1, 8, 6'h2A));
        put(1'b0, 8, 32'd0);
        put(1'b0, 9, 32'hFC00_0000);
        put(1'b0, 10, enc_r(1, 2, 9, 6'h20) | 32'h0000_0040);
        put(1'b0, 11, enc_r(3, 3, 9, 6'h20));
        go();
        chk("R2 pc0", pc_o, 32'd0);
        exp_wb("R6 load a", 1, a);                  nxt();
        chk("R2 pc4", pc_o, 32'd4);
        exp_wb("R6 load b", 2, b);                  nxt();
        exp_wb("R4 add", 3, a + b);                 nxt();
        exp_wb("R4 sub", 4, a - b);                 nxt();
        exp_wb("R4 and", 5, a & b);                 nxt();
        exp_wb("R4 or", 6, a | b);                  nxt();
        exp_wb("R5 slt neg<pos", 7, 32'd1);         nxt();
        exp_wb("R5 slt pos<neg", 8, 32'd0);         nxt();
        exp_quiet("R12 unlisted funct");            nxt();
        chk("R12 pc after funct", pc_o, 32'd36);
        exp_quiet("R12 unlisted opcode");           nxt();
        exp_quiet("R12 nonzero shamt");             nxt();
        chk("R12 pc advance", pc_o, 32'd44);
        exp_wb("R3 rs field add", 9, 32'd8);
    endtask

    task automatic t_reset();
        boot();
        put(1'b0, 0, enc_i(6'h2B, 0, 1, 16));
        put(1'b0, 1, enc_r(1, 2, 3, 6'h20));
        @(negedge clk);
        ld_en = 1'b0;
        @(negedge clk);
        #1;
        chk("R1 pc in reset", pc_o, 32'd0);
        chk("R1 no store in reset", 32'(dm_we_o), 32'd0);
        chk("R1 no wb in reset", 32'(wb_en_o), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 store after reset", 32'(dm_we_o), 32'd1);
        chk("R1 cleared reg", dm_wdata_o, 32'd0);
        nxt();
        exp_wb("R1 cleared sum", 3, 32'd0);
    endtask

    task automatic t_zero();
        boot();
        put(1'b1, 0, 32'h55);
        put(1'b0, 0, enc_i(6'h23, 0, 1, 0));
        put(1'b0, 1, enc_r(1, 1, 0, 6'h20));
        put(1'b0, 2, enc_i(6'h23, 0, 0, 0));
        put(1'b0, 3, enc_r(0, 1, 9, 6'h20));
        go();
        nxt();
        chk("R10 write r0 dropped", 32'(wb_en_o), 32'd0);  nxt();
        chk("R10 load r0 dropped", 32'(wb_en_o), 32'd0);   nxt();
        exp_wb("R10 r0 reads zero", 9, 32'h55);
    endtask

    task automatic t_mem();
        boot();
        put(1'b1, 0, 32'h40);
        put(1'b1, 1, 32'hCAFE_0001);
        put(1'b1, 5, 32'h1234);
        put(1'b0, 0, enc_i(6'h23, 0, 1, 0));
        put(1'b0, 1, enc_i(6'h23, 0, 2, 4));
        put(1'b0, 2, enc_i(6'h2B, 1, 2, -8));
        put(1'b0, 3, enc_i(6'h23, 1, 3, -8));
        put(1'b0, 4, enc_i(6'h23, 0, 5, 20));
        put(1'b0, 5, enc_r(1, 1, 1, 6'h20));
        put(1'b0, 6, enc_r(1, 0, 4, 6'h20));
        go();
        nxt(); nxt();
        chk("R7 store we", 32'(dm_we_o), 32'd1);
        chk("R7 store addr", dm_addr_o, 32'h38);
        chk("R7 store data", dm_wdata_o, 32'hCAFE_0001);
        chk("R7 store no wb", 32'(wb_en_o), 32'd0);       nxt();
        chk("R6 load addr", dm_addr_o, 32'h38);
        exp_wb("R6 load stored", 3, 32'hCAFE_0001);        nxt();
        exp_wb("R13 preloaded data", 5, 32'h1234);        nxt();
        exp_wb("R11 old value read", 1, 32'h80);          nxt();
        exp_wb("R11 new value seen", 4, 32'h80);
    endtask

    task automatic t_branch();
        boot();
        put(1'b1, 0, 32'd9);
        put(1'b1, 1, 32'd9);
        put(1'b1, 2, 32'd3);
        put(1'b0, 0, enc_i(6'h23, 0, 1, 0));
        put(1'b0, 1, enc_i(6'h23, 0, 2, 4));
        put(1'b0, 2, enc_i(6'h23, 0, 3, 8));
        put(1'b0, 3, enc_i(6'h04, 1, 2, 2));
        put(1'b0, 4, enc_r(1, 1, 9, 6'h20));
        put(1'b0, 5, enc_r(1, 1, 9, 6'h20));
        put(1'b0, 6, enc_i(6'h04, 1, 3, 5));
        put(1'b0, 7, enc_j(12));
        put(1'b0, 12, enc_i(6'h04, 0, 0, -1));
        go();
        nxt(); nxt(); nxt();
        chk("R8 branch no wb", 32'(wb_en_o), 32'd0);      nxt();
        chk("R8 taken target", pc_o, 32'd24);             nxt();
        chk("R8 not taken", pc_o, 32'd28);                nxt();
        chk("R9 jump target", pc_o, 32'd48);              nxt();
        chk("R8 negative offset", pc_o, 32'd48);          nxt();
        chk("R8 loop holds", pc_o, 32'd48);
    endtask

    initial begin
        t_alu();
        t_reset();
        t_zero();
        t_mem();
        t_branch();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(HALF * 2.0 * 200000.0);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule